// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between two external interrupt pins and the processor core. Both pins are active low. The first pin carries a maskable request and the second carries a non-maskable request. Each pin passes through a synchronizer. The block then applies the gating rules for that pin and drives one registered request line per pin toward the core. The core supplies its two mask bits as inputs. It also supplies one acknowledge strobe per pin, which clears a latched request once the handler has taken it.

The maskable pin is controlled by a two-bit control register. One bit enables the pin. The other bit chooses between two triggers: a low level, where the request follows the pin, or a falling edge, where the request is latched until acknowledged. The non-maskable pin has no enable. Its request is held back by the core's X mask only until the core first clears that mask after reset. From then on the request cannot be masked again until the next reset.

Top module: `ext_irq_cond`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ctl_q` is 0 (pin disabled, level trigger), and `irq_req` and `nmi_req` are 0. A low maskable pin does not raise `irq_req` until the pin is enabled.
- R2: A cycle with `ctl_we` high loads `ctl_wdata` into the control register, and the new value is visible on `ctl_q` after that clock edge. Bit 0 is the enable. Bit 1 is the trigger: 0 means active-low level, 1 means falling edge.
- R3: In level mode with the pin enabled and `cpu_i_mask` low, `irq_req` follows the inverted pin. It rises on the third rising edge after the pin goes low and falls on the third rising edge after the pin goes high. `irq_ack` has no effect in this mode.
- R4: `irq_req` is 0 on the edge after any cycle in which `cpu_i_mask` is 1. A request latched in edge mode is kept while masked and reappears on the edge after the mask clears.
- R5: In edge mode a falling edge on the pin sets `irq_req` on the third rising edge, and it stays high after the pin returns high. It drops on the edge where `irq_ack` is sampled high.
- R6: In edge mode a pin held low produces only one request, and a rising edge produces none.
- R7: A write that clears the enable bit drops `irq_req` at the same edge as the write and discards any latched request. Re-enabling does not bring the request back.
- R8: Falling edges that arrive while the pin is disabled are discarded.
- R9: A write that changes the trigger mode discards any latched request.
- R10: A falling edge on the non-maskable pin is latched. Once it is unmasked, `nmi_req` stays high until the edge where `nmi_ack` is sampled high.
- R11: From reset until `cpu_x_mask` is first sampled low, `nmi_req` stays 0. A latched request is kept and appears on the edge where `cpu_x_mask` is first sampled low.
- R12: After `cpu_x_mask` has been sampled low once, setting it to 1 has no effect on `nmi_req` until the next reset. After a reset the mask applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| nmi_pin_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 enable, bit 1 trigger (1 = falling edge) |
| ctl_q | output | 2 | Current control register value |
| cpu_i_mask | input | 1 | Core interrupt mask for the maskable request |
| cpu_x_mask | input | 1 | Core mask for the non-maskable request |
| irq_ack | input | 1 | Acknowledge, clears a latched maskable request |
| nmi_ack | input | 1 | Acknowledge, clears a latched non-maskable request |
| irq_req | output | 1 | Conditioned maskable request to the core |
| nmi_req | output | 1 | Conditioned non-maskable request to the core |

## Verification
Most internal state here is a single bit, so a wrong bit shows at the request pins quickly. A stuck edge latch shows as a request that stays high after acknowledge, or as a request that comes back after disable or after a mode change. Either is visible one edge after the acknowledge or the control write. A wrong unlock flag shows on the edge right after `cpu_x_mask` changes, as a non-maskable request that is wrongly held back or wrongly passed. Synchronizer or edge-detect faults move the rising edge of a request away from the third clock after the pin changes, so every request is checked on both sides of that edge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  // bit 1: trigger select, bit 0: enable
  typedef struct packed {
    trig_e mode;
    logic  en;
  } irq_ctl_t;

  localparam int CTL_W = $bits(irq_ctl_t);

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[TOP-1:0], pin};
      end
    end
  endgenerate

  assign lvl = chain[TOP];

endmodule

// File: rtl/eirq_mask_path.sv
module eirq_mask_path
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_n,
  input  logic  en_nxt,
  input  trig_e mode_nxt,
  input  logic  mode_chg,
  input  logic  i_mask,
  input  logic  ack,
  output logic  irq_req
);
  logic lvl, lvl_d, fall;
  logic pend, pend_nxt, req_nxt;

  eirq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (pin_n),
    .lvl (lvl)
  );

  assign fall = lvl_d & ~lvl;

  always_comb begin
    pend_nxt = 1'b0;
    if (en_nxt && (mode_nxt == TRIG_FALL) && !mode_chg)
      pend_nxt = fall | (pend & ~ack);
  end

  always_comb begin
    req_nxt = 1'b0;
    if (en_nxt && !i_mask)
      req_nxt = (mode_nxt == TRIG_FALL) ? pend_nxt : ~lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d   <= 1'b1;
      pend    <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      lvl_d   <= lvl;
      pend    <= pend_nxt;
      irq_req <= req_nxt;
    end
  end

  // R4: core mask blocks the request on the next edge
  p_imask_r4: assert property (@(posedge clk) disable iff (rst)
    i_mask |=> !irq_req);

  // R5: acknowledge without a new edge clears the latched request
  p_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_nxt == TRIG_FALL && ack && !fall) |=> !irq_req);

  // R5: a latched request stays asserted until acknowledged
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack && en_nxt && mode_nxt == TRIG_FALL && !mode_chg && !i_mask)
      |=> irq_req);

endmodule

// File: rtl/eirq_nmi_path.sv
module eirq_nmi_path #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic x_mask,
  input  logic ack,
  output logic nmi_req
);
  logic lvl, lvl_d, fall;
  logic pend, pend_nxt;
  logic unlocked, unl_nxt;

  eirq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (pin_n),
    .lvl (lvl)
  );

  assign fall     = lvl_d & ~lvl;
  assign pend_nxt = fall | (pend & ~ack);
  assign unl_nxt  = unlocked | ~x_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d    <= 1'b1;
      pend     <= 1'b0;
      unlocked <= 1'b0;
      nmi_req  <= 1'b0;
    end else begin
      lvl_d    <= lvl;
      pend     <= pend_nxt;
      unlocked <= unl_nxt;
      nmi_req  <= pend_nxt & unl_nxt;
    end
  end

  // R11: masked until the core first clears X
  p_mask_r11: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && x_mask) |=> !nmi_req);

  // R12: once unlocked, a pending request is delivered whatever X is
  p_nomask_r12: assert property (@(posedge clk) disable iff (rst)
    (unlocked && pend && !ack) |=> nmi_req);

  // R10: acknowledge clears when no new edge arrives
  p_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && !fall) |=> !nmi_req);

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pin_n,
  input  logic             nmi_pin_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             cpu_i_mask,
  input  logic             cpu_x_mask,
  input  logic             irq_ack,
  input  logic             nmi_ack,
  output logic             irq_req,
  output logic             nmi_req
);
  irq_ctl_t ctl, ctl_w, ctl_nxt;
  logic     mode_chg;

  assign ctl_w    = irq_ctl_t'(ctl_wdata);
  assign ctl_nxt  = ctl_we ? ctl_w : ctl;
  assign mode_chg = ctl_we && (ctl_w.mode != ctl.mode);
  assign ctl_q    = ctl;

  always_ff @(posedge clk) begin
    if (rst) ctl <= '{mode: TRIG_LEVEL, en: 1'b0};
    else     ctl <= ctl_nxt;
  end

  eirq_mask_path #(.SYNC_STAGES(SYNC_STAGES)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .pin_n    (irq_pin_n),
    .en_nxt   (ctl_nxt.en),
    .mode_nxt (ctl_nxt.mode),
    .mode_chg (mode_chg),
    .i_mask   (cpu_i_mask),
    .ack      (irq_ack),
    .irq_req  (irq_req)
  );

  eirq_nmi_path #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk     (clk),
    .rst     (rst),
    .pin_n   (nmi_pin_n),
    .x_mask  (cpu_x_mask),
    .ack     (nmi_ack),
    .nmi_req (nmi_req)
  );

  // R2: a write lands in the register on the following edge
  p_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_q == $past(ctl_wdata)));

  // R7: clearing the enable removes the request at the same edge
  p_dis_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_wdata[0]) |=> !irq_req);

endmodule

// File: tb/sim_ext_irq_cond.sv
module sim_ext_irq_cond;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_pin_n = 1'b1, nmi_pin_n = 1'b1;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic [1:0] ctl_q;
  logic       cpu_i_mask = 1'b0, cpu_x_mask = 1'b1;
  logic       irq_ack = 1'b0, nmi_ack = 1'b0;
  logic       irq_req, nmi_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_cond u0 (
    .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cpu_i_mask(cpu_i_mask), .cpu_x_mask(cpu_x_mask),
    .irq_ack(irq_ack), .nmi_ack(nmi_ack),
    .irq_req(irq_req), .nmi_req(nmi_req)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic en, logic mode);
    ctl_we = 1'b1; ctl_wdata = {mode, en};
    step(1);
    ctl_we = 1'b0;
  endtask

  task automatic pulse_irq_ack();
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  task automatic pulse_nmi_ack();
    nmi_ack = 1'b1; step(1); nmi_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_pin_n = 1'b1; nmi_pin_n = 1'b1; cpu_x_mask = 1'b1;
    cpu_i_mask = 1'b0; ctl_we = 1'b0; irq_ack = 1'b0; nmi_ack = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctl_q", ctl_q, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 nmi_req", nmi_req, 0);
    irq_pin_n = 1'b0; step(4);
    chk("R1 disabled pin low", irq_req, 0);
    irq_pin_n = 1'b1; step(3);
  endtask

  task automatic t_ctl();
    wr(1, 1); chk("R2 write 3", ctl_q, 3);
    wr(1, 0); chk("R2 write 1", ctl_q, 1);
    wr(0, 0); chk("R2 write 0", ctl_q, 0);
  endtask

  task automatic t_level();
    wr(1, 0);
    irq_pin_n = 1'b0; step(2);
    chk("R3 before latency", irq_req, 0);
    step(1); chk("R3 rise", irq_req, 1);
    pulse_irq_ack(); chk("R3 ack ignored", irq_req, 1);
    irq_pin_n = 1'b1; step(2);
    chk("R3 still high", irq_req, 1);
    step(1); chk("R3 fall", irq_req, 0);
  endtask

  task automatic t_imask();
    wr(1, 0);
    irq_pin_n = 1'b0; step(3);
    chk("R4 level base", irq_req, 1);
    cpu_i_mask = 1'b1; step(1); chk("R4 masked", irq_req, 0);
    cpu_i_mask = 1'b0; step(1); chk("R4 unmasked", irq_req, 1);
    irq_pin_n = 1'b1; step(3);
    wr(1, 1);
    irq_pin_n = 1'b0; step(3);
    chk("R4 edge base", irq_req, 1);
    cpu_i_mask = 1'b1; step(1); chk("R4 edge masked", irq_req, 0);
    irq_pin_n = 1'b1; step(3);
    chk("R4 edge still masked", irq_req, 0);
    cpu_i_mask = 1'b0; step(1); chk("R4 edge kept", irq_req, 1);
    pulse_irq_ack(); chk("R5 ack after mask", irq_req, 0);
  endtask

  task automatic t_edge();
    wr(1, 1);
    irq_pin_n = 1'b0; step(2);
    chk("R5 before latency", irq_req, 0);
    step(1); chk("R5 rise", irq_req, 1);
    irq_pin_n = 1'b1; step(3);
    chk("R5 held after pin high", irq_req, 1);
    pulse_irq_ack(); chk("R5 ack clears", irq_req, 0);
    irq_pin_n = 1'b0; step(3);
    chk("R6 second edge", irq_req, 1);
    pulse_irq_ack(); step(3);
    chk("R6 held low once", irq_req, 0);
    irq_pin_n = 1'b1; step(4);
    chk("R6 rising edge", irq_req, 0);
  endtask

  task automatic t_disable();
    wr(1, 1);
    irq_pin_n = 1'b0; step(3);
    chk("R7 edge base", irq_req, 1);
    wr(0, 1); chk("R7 drop edge", irq_req, 0);
    wr(1, 1); chk("R7 no resurrect", irq_req, 0);
    step(3); chk("R7 still clear", irq_req, 0);
    irq_pin_n = 1'b1; step(3);
    wr(1, 0);
    irq_pin_n = 1'b0; step(3);
    chk("R7 level base", irq_req, 1);
    wr(0, 0); chk("R7 drop level", irq_req, 0);
    irq_pin_n = 1'b1; step(3);
  endtask

  task automatic t_dis_edge();
    wr(0, 1);
    irq_pin_n = 1'b0; step(3);
    irq_pin_n = 1'b1; step(3);
    wr(1, 1); chk("R8 enable after edge", irq_req, 0);
    step(2); chk("R8 stays clear", irq_req, 0);
  endtask

  task automatic t_mode();
    wr(1, 1);
    irq_pin_n = 1'b0; step(3);
    irq_pin_n = 1'b1; step(3);
    chk("R9 pending base", irq_req, 1);
    wr(1, 0); chk("R9 level pin high", irq_req, 0);
    wr(1, 1); chk("R9 pending dropped", irq_req, 0);
    wr(0, 0);
  endtask

  task automatic t_nmi();
    do_reset();
    nmi_pin_n = 1'b0; step(3);
    chk("R11 masked", nmi_req, 0);
    nmi_pin_n = 1'b1; step(3);
    chk("R11 still masked", nmi_req, 0);
    cpu_x_mask = 1'b0; step(1);
    chk("R11 delivered", nmi_req, 1);
    step(2); chk("R10 held", nmi_req, 1);
    pulse_nmi_ack(); chk("R10 ack", nmi_req, 0);
    cpu_x_mask = 1'b1;
    nmi_pin_n = 1'b0; step(2);
    chk("R10 before latency", nmi_req, 0);
    step(1); chk("R12 x ignored", nmi_req, 1);
    nmi_pin_n = 1'b1; step(3);
    chk("R12 held", nmi_req, 1);
    pulse_nmi_ack(); chk("R10 ack again", nmi_req, 0);
    do_reset();
    nmi_pin_n = 1'b0; step(3);
    chk("R12 masked after reset", nmi_req, 0);
    cpu_x_mask = 1'b0; step(1);
    chk("R12 unmask after reset", nmi_req, 1);
    pulse_nmi_ack();
    nmi_pin_n = 1'b1; step(3);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ctl();
    t_level();
    t_imask();
    t_edge();
    t_disable();
    t_dis_edge();
    t_mode();
    t_nmi();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule